// File: doc/BRIEF.md
# Frame-Locked Adaptive Clock Prescaler

This block turns a fast processing clock into a sequencing tick at 32 times the frame rate. The fast clock runs at any integer multiple of the tick rate between 80 and 90 times it. That is 20.48 MHz to 23.04 MHz for an 8 kHz frame and a 256 kHz tick. The fast clock has no fixed phase relation to the frame sync. The block finds the divide ratio by itself and keeps the tick phase tied to the frame.

The frame sync passes through a two-flop synchronizer and a rising-edge detector. Each detected edge does two things:

- It closes a period measurement, which counts fast-clock cycles per frame.
- It restarts the divider, so that tick 0 of every frame starts at the frame edge.

The measured count is divided by 32 with rounding to give the divide ratio. A lock flag reports that two successive counts were in range and agreed with each other.

Top module: `frame_prescaler`

## Requirements
- R1: If frame_sync_i is first sampled high at clock edge k (after being low), tick_o is high in the cycle that follows edge k+2. This is tick 0 of the frame, and it restarts the divider.
- R2: Each tick lasts one cycle. The following ticks of a frame come exactly ratio_o cycles apart. They use the ratio taken from the period that the frame edge just closed.
- R3: At most 32 ticks are issued between two frame edges. When the frame lasts longer, the remaining cycles carry no tick until the next edge.
- R4: The period is the number of clock cycles between two successive synchronized frame edges. The first edge after reset gives no measurement, so ratio_o and locked_o keep their reset values through the first frame.
- R5: A count N in the window 2550..2890 sets ratio_o to floor((N+16)/32). ratio_o stays within 80..90 and changes only when a measurement arrives.
- R6: A count below 2550 or above 2890 is rejected. ratio_o keeps its value and locked_o is cleared.
- R7: locked_o is set by a measurement that meets all three conditions below. Any other measurement clears locked_o.
  - The measurement is inside the window.
  - The measurement before it was also inside the window.
  - The two counts differ by at most 10.
- R8: While reset is held and just after it, tick_o is 0, ratio_o is 80 and locked_o is 0.
- R9: Each ratio from 80 to 90 is reached when the frame period is 32 times that ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | Frame sync, asynchronous to clk_i |
| tick_o | output | 1 | One-cycle sequencing tick enable |
| ratio_o | output | 7 | Current divide ratio |
| locked_o | output | 1 | Ratio found and frame period steady |

## Verification
The bench walks the whole ratio range. It also probes the following corners:

- Rounding at N=2575 against N=2576. Truncating instead of rounding gives 80 in both cases.
- Both sides of each window edge (2549/2550, 2890/2891). An off-by-one check keeps a stale ratio or takes a bad one.
- A count difference of exactly 10 against 11. A wrong comparison locks on drift or never locks.
- An overlong frame, which must still carry exactly 32 ticks. A divider without the cap emits extra ticks.

Every cycle of tick_o is compared with a model of the frame edges. A design that re-phases late, or switches to the new ratio late, would show its ticks shifted.

// File: rtl/fpre_pkg.sv
package fpre_pkg;

   // Lock tracker states: no accepted count, one accepted count, locked.
   typedef enum logic [1:0] {
      LK_NONE   = 2'd0,
      LK_ARMED  = 2'd1,
      LK_LOCKED = 2'd2
   } fpre_lock_e;

   localparam int unsigned FPRE_TICKS_DEFAULT = 32;
   localparam int unsigned FPRE_RMIN_DEFAULT  = 80;
   localparam int unsigned FPRE_RMAX_DEFAULT  = 90;
   localparam int unsigned FPRE_TOL_DEFAULT   = 10;

endpackage

// File: rtl/fpre_edge_sync.sv
module fpre_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   logic [STAGES-1:0] stage_q;
   logic              last_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= 1'b0;
            else         stage_q[g] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= 1'b0;
            else         stage_q[g] <= stage_q[g-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b0;
      else         last_q <= stage_q[STAGES-1];
   end

   assign rise_o = stage_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/fpre_period_meter.sv
module fpre_period_meter #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rise_i,
   output logic [CNT_W-1:0] count_o,
   output logic             vld_o
);

   logic [CNT_W-1:0] run_q;
   logic             seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= '0;
         seen_q  <= 1'b0;
         count_o <= '0;
         vld_o   <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (rise_i) begin
            run_q  <= CNT_W'(1);
            seen_q <= 1'b1;
            if (seen_q) begin
               count_o <= run_q;
               vld_o   <= 1'b1;
            end
         end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fpre_ratio_lock.sv
module fpre_ratio_lock
   import fpre_pkg::*;
#(
   parameter int unsigned TICKS         = 32,
   parameter int unsigned RATIO_MIN     = 80,
   parameter int unsigned RATIO_MAX     = 90,
   parameter int unsigned TOL           = 10,
   parameter int unsigned CNT_W         = 13,
   parameter int unsigned RW            = 7,
   parameter int unsigned RATIO_RESET   = 80,
   parameter bit          ROUND_NEAREST = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             vld_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [RW-1:0]    ratio_o,
   output logic             locked_o
);

   localparam int unsigned WIN_LO = RATIO_MIN * TICKS - TOL;
   localparam int unsigned WIN_HI = RATIO_MAX * TICKS + TOL;

   fpre_lock_e       state_q;
   logic [CNT_W-1:0] prev_q;
   logic             in_win;
   logic [CNT_W-1:0] delta;
   logic             close;
   logic [CNT_W:0]   quot;
   logic [RW-1:0]    ratio_next;

   assign in_win = (count_i >= CNT_W'(WIN_LO)) && (count_i <= CNT_W'(WIN_HI));
   assign delta  = (count_i > prev_q) ? (count_i - prev_q) : (prev_q - count_i);
   assign close  = (delta <= CNT_W'(TOL));

   if (ROUND_NEAREST) begin : g_round
      assign quot = ({1'b0, count_i} + (CNT_W+1)'(TICKS / 2)) / (CNT_W+1)'(TICKS);
   end else begin : g_trunc
      assign quot = {1'b0, count_i} / (CNT_W+1)'(TICKS);
   end

   always_comb begin
      if (quot < (CNT_W+1)'(RATIO_MIN))      ratio_next = RW'(RATIO_MIN);
      else if (quot > (CNT_W+1)'(RATIO_MAX)) ratio_next = RW'(RATIO_MAX);
      else                                   ratio_next = RW'(quot);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ratio_o <= RW'(RATIO_RESET);
         state_q <= LK_NONE;
         prev_q  <= '0;
      end else if (vld_i) begin
         prev_q <= count_i;
         if (!in_win) begin
            state_q <= LK_NONE;
         end else begin
            ratio_o <= ratio_next;
            if (state_q == LK_NONE) state_q <= LK_ARMED;
            else if (close)         state_q <= LK_LOCKED;
            else                    state_q <= LK_ARMED;
         end
      end
   end

   assign locked_o = (state_q == LK_LOCKED);

endmodule

// File: rtl/fpre_tick_divider.sv
module fpre_tick_divider #(
   parameter int unsigned TICKS = 32,
   parameter int unsigned RW    = 7
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          rise_i,
   input  logic [RW-1:0] ratio_i,
   output logic          tick_o
);

   localparam int unsigned IW = $clog2(TICKS + 1);

   logic [RW-1:0] cnt_q;
   logic [IW-1:0] idx_q;
   logic          wrap;

   assign wrap = (cnt_q >= ratio_i - RW'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         idx_q  <= '0;
         tick_o <= 1'b0;
      end else if (rise_i) begin
         cnt_q  <= '0;
         idx_q  <= IW'(1);
         tick_o <= 1'b1;
      end else if (wrap) begin
         cnt_q <= '0;
         if (idx_q < IW'(TICKS)) begin
            idx_q  <= idx_q + 1'b1;
            tick_o <= 1'b1;
         end else begin
            tick_o <= 1'b0;
         end
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         tick_o <= 1'b0;
      end
   end

endmodule

// File: rtl/frame_prescaler.sv
module frame_prescaler
   import fpre_pkg::*;
#(
   parameter int unsigned TICKS         = FPRE_TICKS_DEFAULT,
   parameter int unsigned RATIO_MIN     = FPRE_RMIN_DEFAULT,
   parameter int unsigned RATIO_MAX     = FPRE_RMAX_DEFAULT,
   parameter int unsigned TOL           = FPRE_TOL_DEFAULT,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned RATIO_RESET   = FPRE_RMIN_DEFAULT,
   parameter bit          ROUND_NEAREST = 1'b1,
   localparam int unsigned RW           = $clog2(RATIO_MAX + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          frame_sync_i,
   output logic          tick_o,
   output logic [RW-1:0] ratio_o,
   output logic          locked_o
);

   localparam int unsigned CNT_W = $clog2(2 * (RATIO_MAX * TICKS + TOL));

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("frame_prescaler: SYNC_STAGES must be at least 2");
   end
   if (RATIO_MIN < 2 || RATIO_MIN > RATIO_MAX) begin : g_chk_ratio
      $error("frame_prescaler: ratio range is invalid");
   end
   if (RATIO_RESET < RATIO_MIN || RATIO_RESET > RATIO_MAX) begin : g_chk_reset
      $error("frame_prescaler: RATIO_RESET outside ratio range");
   end
   if (TICKS < 2 || TOL >= RATIO_MIN * TICKS) begin : g_chk_ticks
      $error("frame_prescaler: TICKS or TOL invalid");
   end

   logic             rise_w;
   logic             meas_vld_w;
   logic [CNT_W-1:0] meas_cnt_w;

   fpre_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (frame_sync_i),
      .rise_o  (rise_w)
   );

   fpre_period_meter #(
      .CNT_W (CNT_W)
   ) u_meter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rise_i  (rise_w),
      .count_o (meas_cnt_w),
      .vld_o   (meas_vld_w)
   );

   fpre_ratio_lock #(
      .TICKS         (TICKS),
      .RATIO_MIN     (RATIO_MIN),
      .RATIO_MAX     (RATIO_MAX),
      .TOL           (TOL),
      .CNT_W         (CNT_W),
      .RW            (RW),
      .RATIO_RESET   (RATIO_RESET),
      .ROUND_NEAREST (ROUND_NEAREST)
   ) u_ratio (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vld_i    (meas_vld_w),
      .count_i  (meas_cnt_w),
      .ratio_o  (ratio_o),
      .locked_o (locked_o)
   );

   fpre_tick_divider #(
      .TICKS (TICKS),
      .RW    (RW)
   ) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rise_i  (rise_w),
      .ratio_i (ratio_o),
      .tick_o  (tick_o)
   );

endmodule

// File: rtl/fpre_checker.sv
module fpre_checker #(
   parameter int unsigned RATIO_MIN = 80,
   parameter int unsigned RATIO_MAX = 90,
   parameter int unsigned RW        = 7
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          rise,
   input logic          meas_vld,
   input logic          tick,
   input logic [RW-1:0] ratio,
   input logic          locked
);

   AST_TICK_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise |=> tick); // R1

   AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && !rise) |=> !tick); // R2

   AST_RATIO_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ratio >= RW'(RATIO_MIN)) && (ratio <= RW'(RATIO_MAX))); // R5

   AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !meas_vld |=> $stable(ratio)); // R5

   AST_LOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !meas_vld |=> $stable(locked)); // R7

endmodule

bind frame_prescaler fpre_checker #(
   .RATIO_MIN (RATIO_MIN),
   .RATIO_MAX (RATIO_MAX),
   .RW        (RW)
) u_fpre_checker (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .rise     (rise_w),
   .meas_vld (meas_vld_w),
   .tick     (tick_o),
   .ratio    (ratio_o),
   .locked   (locked_o)
);

// File: tb/test_frame_prescaler.sv
`timescale 1ns/1ps
module test_frame_prescaler;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fs = 1'b0;
   logic       tick;
   logic [6:0] ratio;
   logic       locked;

   always #2.5 clk = ~clk;

   frame_prescaler i_frame_prescaler (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .frame_sync_i (fs),
      .tick_o       (tick),
      .ratio_o      (ratio),
      .locked_o     (locked)
   );

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   // bench model
   bit  pipe0, pipe1, pipe2, pipe3;
   int  d = 0;
   bit  active = 1'b0;
   int  r_exp = 80, r_pend = 80;
   bit  lock_pend = 1'b0;
   bit  have_frame = 1'b0;
   int  last_len = 0;
   bit  prev_ok = 1'b0;
   int  prev_m = 0;
   int  tick_err;
   int  tick_cnt;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input bit lvl, input bit ev, input bit count_it);
      bit expt;
      @(negedge clk);
      fs = lvl;
      pipe3 = pipe2; pipe2 = pipe1; pipe1 = pipe0; pipe0 = ev;
      if (pipe3) begin
         d = 0; active = 1'b1; r_exp = r_pend;
      end else begin
         d++;
      end
      if (active) begin
         expt = ((d % r_exp) == 0) && ((d / r_exp) < 32);
         if (tick !== expt) tick_err++;
         if (count_it && tick === 1'b1) tick_cnt++;
      end
   endtask

   task automatic run_frame(input int len, input string req);
      int m;
      bit ok;
      int diff;
      int exp_cnt;
      if (have_frame) begin
         m  = last_len;
         ok = (m >= 2550) && (m <= 2890);
         diff = (m > prev_m) ? m - prev_m : prev_m - m;
         if (ok) r_pend = (m + 16) / 32;
         lock_pend = ok && prev_ok && (diff <= 10);
         prev_ok = ok;
         prev_m  = m;
      end
      have_frame = 1'b1;
      last_len   = len;
      tick_err = 0;
      tick_cnt = 0;
      for (int i = 0; i < len; i++) begin
         step(i < 8, i == 0, i >= 3);
         if (i == 200) begin
            check(ratio == 7'(r_pend), req, "ratio_o", int'(ratio), r_pend);
            check(locked == lock_pend, req, "locked_o", int'(locked), int'(lock_pend));
         end
      end
      check(tick_err == 0, "R2", "tick pattern mismatches", tick_err, 0);
      exp_cnt = (len + r_pend - 1) / r_pend;
      if (exp_cnt > 32) exp_cnt = 32;
      check(tick_cnt == exp_cnt, "R3", "ticks in frame", tick_cnt, exp_cnt);
   endtask

   initial begin
      #(190000 * 5);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R8: reset values
      check(tick == 1'b0, "R8", "tick_o in reset", int'(tick), 0);
      check(ratio == 7'd80, "R8", "ratio_o in reset", int'(ratio), 80);
      check(locked == 1'b0, "R8", "locked_o in reset", int'(locked), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(tick == 1'b0, "R8", "tick_o after reset", int'(tick), 0);
      check(ratio == 7'd80, "R8", "ratio_o after reset", int'(ratio), 80);
      repeat (10) @(negedge clk);

      // R1: first frame edge, tick 0 placement
      for (int i = 0; i < 6; i++) begin
         step(1'b1, i == 0, 1'b0);
         if (i == 3) check(tick == 1'b1, "R1", "tick 0 after edge", int'(tick), 1);
         if (i == 4) check(tick == 1'b0, "R1", "tick 0 width", int'(tick), 0);
      end
      for (int i = 6; i < 2592; i++) begin
         step(i < 8, 1'b0, 1'b0);
         if (i == 200) begin
            check(ratio == 7'd80, "R4", "ratio_o first frame", int'(ratio), 80);
            check(locked == 1'b0, "R4", "locked_o first frame", int'(locked), 0);
         end
      end
      have_frame = 1'b1;
      last_len   = 2592;

      run_frame(2592, "R4");   // first measurement: 81, not locked
      run_frame(2592, "R7");   // second agreeing: locked

      // R9: sweep every ratio
      for (int r = 80; r <= 90; r++) begin
         run_frame(32 * r, "R9");
         run_frame(32 * r, "R9");
      end

      // R7: drift of 10 vs 11
      run_frame(2599, "R7");
      run_frame(2589, "R7");
      run_frame(2600, "R7");
      run_frame(2576, "R7");

      // R5: rounding boundary
      run_frame(2575, "R5");
      run_frame(2575, "R5");
      run_frame(2549, "R5");

      // R6: window edges
      run_frame(2550, "R6");
      run_frame(2891, "R6");
      run_frame(2890, "R6");
      run_frame(3000, "R6");
      run_frame(2560, "R6");
      run_frame(2560, "R6");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule